// File: doc/BRIEF.md
# Two-Read One-Write Register Bank with Observation Taps

This block stores thirty-two 32-bit general registers for a small processor datapath. Two read ports are purely combinational: each takes a 5-bit register number and returns that register's contents in the same cycle. One write port stores a data word into the addressed register on the rising clock edge, but only while its write strobe is high. Register number 0 cannot be changed and always returns zero. This gives the datapath a constant-zero source and a place to send results that are thrown away.

Eight fixed registers are also driven onto their own outputs at all times: numbers 1, 2, 5, 6, 7, 8, 9 and 10. A test environment can watch them without spending a read port. A synchronous reset clears the whole bank.

Top module: `gpr_bank`

## Requirements
- R1: When `rst` is 1 at a rising edge of `clk`, every register becomes zero. After that edge, both read ports and all eight taps return 0.
- R2: `rd_data_a` always equals the register numbered `rd_addr_a`, and `rd_data_b` always equals the register numbered `rd_addr_b`. Each is combinational, and the two ports are independent of each other.
- R3: When `wr_en` is 1 and `wr_addr` is not 0 at a rising edge (with `rst` at 0), `wr_data` is stored into register `wr_addr`. A read of that register in the cycle before the edge still returns the old value. The new value appears right after the edge.
- R4: When `wr_en` is 0 at a rising edge, no register changes, whatever `wr_addr` and `wr_data` hold.
- R5: Register 0 reads as zero on both ports at all times. A write addressed to register 0 is discarded and leaves every other register unchanged.
- R6: Outputs `tap_x1`, `tap_x2`, `tap_x5`, `tap_x6`, `tap_x7`, `tap_x8`, `tap_x9` and `tap_x10` show registers 1, 2, 5, 6, 7, 8, 9 and 10. They change at the same edge as the read ports.
- R7: When `rst` and `wr_en` are both 1 at the same edge, the reset wins and the addressed register becomes zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_addr_a | input | 5 | Register number for read port A |
| rd_data_a | output | 32 | Contents of register `rd_addr_a` |
| rd_addr_b | input | 5 | Register number for read port B |
| rd_data_b | output | 32 | Contents of register `rd_addr_b` |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 5 | Register number to write |
| wr_data | input | 32 | Word to write |
| tap_x1 | output | 32 | Register 1 |
| tap_x2 | output | 32 | Register 2 |
| tap_x5 | output | 32 | Register 5 |
| tap_x6 | output | 32 | Register 6 |
| tap_x7 | output | 32 | Register 7 |
| tap_x8 | output | 32 | Register 8 |
| tap_x9 | output | 32 | Register 9 |
| tap_x10 | output | 32 | Register 10 |

## Verification
Some properties are checked on every cycle:
- A qualified write lands in exactly the addressed register.
- With the strobe low, the bank holds still.
- Register 0 returns zero on both ports.
- The write decoder raises at most one strobe, and none for register 0.
- Both read ports agree when they select the same register.
- Each tap agrees with a read port pointed at the same register.

Some behaviour can only be shown by the bench's scenarios:
- The reset clears the bank, including when a write arrives at the same edge.
- A write is not visible before its edge.
- Every one of the 32 addresses returns the right word on both ports after full sweeps of distinct data.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  localparam int GPR_DATA_W = 32;
  localparam int GPR_ADDR_W = 5;
  localparam int GPR_NUM_TAPS = 8;

  // Register number observed by tap k: 1, 2, then 5 through 10.
  function automatic int tap_reg(input int k);
    return (k < 2) ? k + 1 : k + 3;
  endfunction
endpackage

// File: rtl/gpr_wr_decode.sv
module gpr_wr_decode #(
  parameter int ADDR_W = 5,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output logic [DEPTH-1:1]  strobe
);
  always_comb begin
    for (int i = 1; i < DEPTH; i++) begin
      strobe[i] = we && (addr == ADDR_W'(i));
    end
  end
endmodule

// File: rtl/gpr_cell.sv
module gpr_cell #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (we) begin
      q <= d;
    end
  end
endmodule

// File: rtl/gpr_read_port.sv
module gpr_read_port #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic [DEPTH-1:0][DATA_W-1:0] regs,
  input  logic [ADDR_W-1:0]            addr,
  output logic [DATA_W-1:0]            data
);
  assign data = regs[addr];
endmodule

// File: rtl/gpr_bank.sv
module gpr_bank
  import gpr_pkg::*;
#(
  parameter int DATA_W = GPR_DATA_W,
  parameter int ADDR_W = GPR_ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rd_addr_a,
  output logic [DATA_W-1:0] rd_data_a,
  input  logic [ADDR_W-1:0] rd_addr_b,
  output logic [DATA_W-1:0] rd_data_b,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] tap_x1,
  output logic [DATA_W-1:0] tap_x2,
  output logic [DATA_W-1:0] tap_x5,
  output logic [DATA_W-1:0] tap_x6,
  output logic [DATA_W-1:0] tap_x7,
  output logic [DATA_W-1:0] tap_x8,
  output logic [DATA_W-1:0] tap_x9,
  output logic [DATA_W-1:0] tap_x10
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0][DATA_W-1:0] regs_q;
  logic [DEPTH-1:1]             wr_strobe;
  logic [GPR_NUM_TAPS-1:0][DATA_W-1:0] taps;

  gpr_wr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .we    (wr_en),
    .addr  (wr_addr),
    .strobe(wr_strobe)
  );

  // R3 single target; R5 nothing selected when register 0 is addressed
  a_r3_single_strobe: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr != '0) |-> ($countones(wr_strobe) == 1));
  a_r5_x0_no_strobe: assert property (@(posedge clk) disable iff (rst)
    (wr_addr == '0) |-> (wr_strobe == '0));

  for (genvar i = 0; i < DEPTH; i++) begin : g_reg
    if (i == 0) begin : g_zero
      assign regs_q[i] = '0;
    end else begin : g_store
      gpr_cell #(.DATA_W(DATA_W)) u_cell (
        .clk(clk),
        .rst(rst),
        .we (wr_strobe[i]),
        .d  (wr_data),
        .q  (regs_q[i])
      );
    end
  end

  // R3 the word lands in the addressed register; R4 bank holds with strobe low
  a_r3_write_lands: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr != '0) |=> (regs_q[$past(wr_addr)] == $past(wr_data)));
  a_r4_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(regs_q));

  gpr_read_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd_a (
    .regs(regs_q), .addr(rd_addr_a), .data(rd_data_a)
  );
  gpr_read_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd_b (
    .regs(regs_q), .addr(rd_addr_b), .data(rd_data_b)
  );

  // R2 the two ports agree on a shared address; R5 register 0 reads zero
  a_r2_ports_agree: assert property (@(posedge clk) disable iff (rst)
    (rd_addr_a == rd_addr_b) |-> (rd_data_a == rd_data_b));
  a_r5_zero_a: assert property (@(posedge clk) disable iff (rst)
    (rd_addr_a == '0) |-> (rd_data_a == '0));
  a_r5_zero_b: assert property (@(posedge clk) disable iff (rst)
    (rd_addr_b == '0) |-> (rd_data_b == '0));

  for (genvar k = 0; k < GPR_NUM_TAPS; k++) begin : g_tap
    assign taps[k] = regs_q[tap_reg(k)];
    // R6 each tap matches read port A aimed at the same register
    a_r6_tap_vs_port: assert property (@(posedge clk) disable iff (rst)
      (rd_addr_a == ADDR_W'(tap_reg(k))) |-> (rd_data_a == taps[k]));
  end

  assign tap_x1  = taps[0];
  assign tap_x2  = taps[1];
  assign tap_x5  = taps[2];
  assign tap_x6  = taps[3];
  assign tap_x7  = taps[4];
  assign tap_x8  = taps[5];
  assign tap_x9  = taps[6];
  assign tap_x10 = taps[7];
endmodule

// File: tb/test_gpr_bank.sv
`timescale 1ns/1ps
module test_gpr_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        wr_en = 1'b0;
  logic [31:0] rd_data_a, rd_data_b;
  logic [31:0] tap_x1, tap_x2, tap_x5, tap_x6, tap_x7, tap_x8, tap_x9, tap_x10;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] exp_q [32];

  always #2 clk = ~clk;

  gpr_bank i_gpr_bank (
    .clk(clk), .rst(rst),
    .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
    .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tap_x1(tap_x1), .tap_x2(tap_x2), .tap_x5(tap_x5), .tap_x6(tap_x6),
    .tap_x7(tap_x7), .tap_x8(tap_x8), .tap_x9(tap_x9), .tap_x10(tap_x10)
  );

  function automatic logic [31:0] pat(input int idx, input logic [31:0] salt);
    return (32'(idx) + 32'd1) * 32'h9E37_79B9 ^ salt;
  endfunction

  task automatic cmp(input string req, input logic [31:0] got, input logic [31:0] want);
    n_cmp++;
    if (got !== want) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, want);
    end
  endtask

  task automatic check_taps(input string req);
    cmp({req, " tap_x1"},  tap_x1,  exp_q[1]);
    cmp({req, " tap_x2"},  tap_x2,  exp_q[2]);
    cmp({req, " tap_x5"},  tap_x5,  exp_q[5]);
    cmp({req, " tap_x6"},  tap_x6,  exp_q[6]);
    cmp({req, " tap_x7"},  tap_x7,  exp_q[7]);
    cmp({req, " tap_x8"},  tap_x8,  exp_q[8]);
    cmp({req, " tap_x9"},  tap_x9,  exp_q[9]);
    cmp({req, " tap_x10"}, tap_x10, exp_q[10]);
  endtask

  // Sweep every address on both ports (B runs in reverse), then the taps.
  task automatic check_all(input string req);
    for (int a = 0; a < 32; a++) begin
      rd_addr_a = 5'(a);
      rd_addr_b = 5'(31 - a);
      #0.1;
      cmp({req, " port A"}, rd_data_a, exp_q[a]);
      cmp({req, " port B"}, rd_data_b, exp_q[31 - a]);
    end
    check_taps({req, " R6"});
  endtask

  // Drive at a falling edge, let one rising edge act, return at the next falling edge.
  task automatic wr(input int a, input logic [31:0] d, input bit en);
    @(negedge clk);
    wr_addr = 5'(a);
    wr_data = d;
    wr_en = en;
    @(posedge clk);
    #0.5;
    wr_en = 1'b0;
    if (en && a != 0) exp_q[a] = d;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stim
    for (int i = 0; i < 32; i++) exp_q[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check_all("R1 after reset");

    // R3 fill every register, including a discarded write to register 0 (R5)
    for (int a = 0; a < 32; a++) wr(a, pat(a, 32'h0), 1'b1);
    check_all("R3 first sweep");
    for (int a = 31; a >= 0; a--) wr(a, ~pat(a, 32'h5A5A_0F0F), 1'b1);
    check_all("R3 second sweep");

    // R5 all-ones to register 0 leaves it zero and the others alone
    wr(0, 32'hFFFF_FFFF, 1'b1);
    check_all("R5 x0 write dropped");

    // R4 strobe low to every address: nothing moves
    for (int a = 0; a < 32; a++) wr(a, 32'hDEAD_0000 | 32'(a), 1'b0);
    check_all("R4 idle writes");

    // R3 same-cycle read returns old value; new value after the edge (R6 tap too)
    @(negedge clk);
    wr_addr = 5'd7; wr_data = 32'hC0FF_EE07; wr_en = 1'b1;
    rd_addr_a = 5'd7; rd_addr_b = 5'd7;
    #0.5;
    cmp("R3 pre-edge port A", rd_data_a, exp_q[7]);
    cmp("R6 pre-edge tap_x7", tap_x7, exp_q[7]);
    @(posedge clk);
    #0.5;
    wr_en = 1'b0;
    exp_q[7] = 32'hC0FF_EE07;
    cmp("R3 post-edge port A", rd_data_a, exp_q[7]);
    cmp("R3 post-edge port B", rd_data_b, exp_q[7]);
    cmp("R6 post-edge tap_x7", tap_x7, exp_q[7]);
    @(negedge clk);

    // R2 random traffic with random address pairs
    for (int n = 0; n < 300; n++) begin
      wr(int'($urandom_range(31)), $urandom, 1'($urandom_range(1)));
      rd_addr_a = 5'($urandom_range(31));
      rd_addr_b = 5'($urandom_range(31));
      #0.1;
      cmp("R2 random A", rd_data_a, exp_q[rd_addr_a]);
      cmp("R2 random B", rd_data_b, exp_q[rd_addr_b]);
    end
    check_all("R2 after random");

    // R7 reset and write at the same edge: reset wins
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b1; wr_addr = 5'd9; wr_data = 32'h1234_5678;
    @(posedge clk);
    #0.5;
    wr_en = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 32; i++) exp_q[i] = '0;
    check_all("R7 reset over write");
    check_all("R1 cleared bank");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule